// File: doc/BRIEF.md
# Pipelined Control Decode and Stage Propagation

This block turns the instruction word held in the decode stage of a five-stage pipeline (fetch, decode, execute, memory, write-back) into control bits. It then moves those bits down the pipeline in three registers: decode-to-execute, execute-to-memory and memory-to-write-back. Each group of bits rides with its instruction and drops out once its consuming stage has seen it. Execute-stage bits appear one cycle after decode, memory-stage bits two cycles after, and write-back bits three cycles after. The destination register number is picked in execute, from either the rd or the rt field, and travels to write-back. Nothing is held after write-back.

The surrounding datapath (ALU, memories, register file) reads the per-stage outputs. There is no enable on the stage registers: they load on every clock. Two cancel inputs turn an instruction into a harmless no-op. A bubble request acts on the instruction entering execute. A flush request acts on the instruction leaving execute. Register-type instructions do nothing in the memory stage, so every register-file write lands in stage 5 and the single write port is never contended. The decoder sorts each opcode into one of seven named classes: register, load, store, branch, or-immediate, add-immediate and unrecognised. Each class selects one fixed control pattern.

Top module: `pcp_ctrl_pipe`

## Requirements
- R1: While reset is asserted and right after it, every stage output is 0. The stage registers hold a no-op.
- R2: Execute outputs appear one clock after the instruction is presented. The opcode is bits 31:26 and the funct field is bits 5:0. The decode is as follows. Opcode 0x00 with funct 0x20/0x22/0x24/0x25/0x2A gives ALU function 0/1/2/3/4, register operand, rd select and sign extend. 0x23 (load) and 0x2B (store) give function 0, immediate operand and sign extend. 0x04 (branch) gives function 1, register operand and sign extend. 0x0D gives function 3, immediate operand and zero extend. 0x08 gives function 0, immediate operand and sign extend.
- R3: Memory outputs appear two clocks after the instruction. Load sets the read enable, store sets the write enable, and opcode 0x04 sets the branch bit.
- R4: Write-back outputs appear three clocks after the instruction. Register-type, load, 0x0D and 0x08 set the register write. Load also sets the memory-to-register select.
- R5: The destination is rd (bits 15:11) when the rd select is set, and rt (bits 20:16) otherwise. The number chosen in execute is carried unchanged through the memory and write-back outputs.
- R6: A register-type instruction shows no memory read or memory write in the memory stage. Its register write appears only in the write-back stage.
- R7: A bubble presented with an instruction clears that instruction's register write, memory write and branch bits. All of its other execute controls stay as decoded.
- R8: A flush clears the register write, memory write and branch bits of the instruction in execute, as it moves into the memory stage.
- R9: An unrecognised opcode, or opcode 0x00 with any other funct value, yields all control bits 0. All write enables are therefore deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_instr | input | 32 | Instruction in the decode stage |
| id_bubble | input | 1 | Turn the decoding instruction into a no-op |
| ex_flush | input | 1 | Cancel the instruction in execute |
| ex_sign_ext | output | 1 | Immediate sign extend (0 = zero extend) |
| ex_alu_imm | output | 1 | ALU second operand is the immediate |
| ex_alu_fn | output | 3 | ALU function code |
| ex_dst_rd | output | 1 | Destination is rd (0 = rt) |
| ex_dst_reg | output | 5 | Resolved destination register in execute |
| mem_wr_en | output | 1 | Data memory write |
| mem_rd_en | output | 1 | Data memory read |
| mem_branch | output | 1 | Branch instruction in memory stage |
| mem_dst_reg | output | 5 | Destination register in memory stage |
| wb_mem_to_reg | output | 1 | Write-back source is memory data |
| wb_reg_wr | output | 1 | Register-file write |
| wb_dst_reg | output | 5 | Register-file write address |

## Verification
The hardest situation to reach is a cancel request landing on the one instruction whose side effect it must remove, while that side effect is still two stages away from any port. Examples are a bubble on an add-immediate, whose register write only shows in write-back, and a flush arriving exactly as a store leaves execute. Directed sequences place these cases on chosen instructions, with no-op fillers around them so each effect stands alone at the port. Long random runs then mix bubbles and flushes at random points, with opcodes and funct values that include unrecognised ones, and compare every stage against a bench-side model.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_SLT = 3'd4
    } alu_fn_e;

    typedef enum logic [2:0] {
        CLS_REG,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_ORI,
        CLS_ADDI,
        CLS_NONE
    } instr_cls_e;

    typedef struct packed {
        logic    sign_ext;
        logic    alu_imm;
        alu_fn_e alu_fn;
        logic    dst_rd;
    } ex_ctl_t;

    typedef struct packed {
        logic wr;
        logic rd;
        logic branch;
    } mem_ctl_t;

    typedef struct packed {
        logic mem_to_reg;
        logic reg_wr;
    } wb_ctl_t;

endpackage

// File: rtl/pcp_decoder.sv
module pcp_decoder
    import pcp_pkg::*;
#(
    parameter int OPC_W = 6,
    parameter int FUN_W = 6
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic [FUN_W-1:0] funct,
    output ex_ctl_t          ex_ctl,
    output mem_ctl_t         mem_ctl,
    output wb_ctl_t          wb_ctl
);

    instr_cls_e cls;
    alu_fn_e    rfn;
    logic       rfn_ok;

    // classify opcode
    always_comb begin
        unique case (opcode)
            OPC_W'(6'h00): cls = CLS_REG;
            OPC_W'(6'h23): cls = CLS_LOAD;
            OPC_W'(6'h2B): cls = CLS_STORE;
            OPC_W'(6'h04): cls = CLS_BRANCH;
            OPC_W'(6'h0D): cls = CLS_ORI;
            OPC_W'(6'h08): cls = CLS_ADDI;
            default:       cls = CLS_NONE;
        endcase
    end

    // register-type function field
    always_comb begin
        rfn_ok = 1'b1;
        rfn    = FN_ADD;
        case (funct)
            FUN_W'(6'h20): rfn = FN_ADD;
            FUN_W'(6'h22): rfn = FN_SUB;
            FUN_W'(6'h24): rfn = FN_AND;
            FUN_W'(6'h25): rfn = FN_OR;
            FUN_W'(6'h2A): rfn = FN_SLT;
            default:       rfn_ok = 1'b0;
        endcase
    end

    // control pattern per class
    always_comb begin
        ex_ctl  = '0;
        mem_ctl = '0;
        wb_ctl  = '0;
        unique case (cls)
            CLS_REG: begin
                if (rfn_ok) begin
                    ex_ctl.sign_ext = 1'b1;
                    ex_ctl.alu_fn   = rfn;
                    ex_ctl.dst_rd   = 1'b1;
                    wb_ctl.reg_wr   = 1'b1;
                end
            end
            CLS_LOAD: begin
                ex_ctl.sign_ext   = 1'b1;
                ex_ctl.alu_imm    = 1'b1;
                mem_ctl.rd        = 1'b1;
                wb_ctl.mem_to_reg = 1'b1;
                wb_ctl.reg_wr     = 1'b1;
            end
            CLS_STORE: begin
                ex_ctl.sign_ext = 1'b1;
                ex_ctl.alu_imm  = 1'b1;
                mem_ctl.wr      = 1'b1;
            end
            CLS_BRANCH: begin
                ex_ctl.sign_ext = 1'b1;
                ex_ctl.alu_fn   = FN_SUB;
                mem_ctl.branch  = 1'b1;
            end
            CLS_ORI: begin
                ex_ctl.alu_imm = 1'b1;
                ex_ctl.alu_fn  = FN_OR;
                wb_ctl.reg_wr  = 1'b1;
            end
            CLS_ADDI: begin
                ex_ctl.sign_ext = 1'b1;
                ex_ctl.alu_imm  = 1'b1;
                wb_ctl.reg_wr   = 1'b1;
            end
            CLS_NONE: begin
                ex_ctl  = '0;
                mem_ctl = '0;
                wb_ctl  = '0;
            end
        endcase
    end

endmodule

// File: rtl/pcp_stage_reg.sv
module pcp_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/pcp_ctrl_pipe.sv
module pcp_ctrl_pipe
    import pcp_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int OPC_W   = 6,
    parameter int FUN_W   = 6,
    parameter int REG_AW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSTR_W-1:0] id_instr,
    input  logic              id_bubble,
    input  logic              ex_flush,
    output logic              ex_sign_ext,
    output logic              ex_alu_imm,
    output logic [2:0]        ex_alu_fn,
    output logic              ex_dst_rd,
    output logic [REG_AW-1:0] ex_dst_reg,
    output logic              mem_wr_en,
    output logic              mem_rd_en,
    output logic              mem_branch,
    output logic [REG_AW-1:0] mem_dst_reg,
    output logic              wb_mem_to_reg,
    output logic              wb_reg_wr,
    output logic [REG_AW-1:0] wb_dst_reg
);

    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RS_LSB  = OPC_LSB - REG_AW;
    localparam int RT_LSB  = RS_LSB - REG_AW;
    localparam int RD_LSB  = RT_LSB - REG_AW;

    typedef struct packed {
        ex_ctl_t           ex;
        mem_ctl_t          mem;
        wb_ctl_t           wb;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
    } idex_t;

    typedef struct packed {
        mem_ctl_t          mem;
        wb_ctl_t           wb;
        logic [REG_AW-1:0] dst;
    } exmem_t;

    typedef struct packed {
        wb_ctl_t           wb;
        logic [REG_AW-1:0] dst;
    } memwb_t;

    localparam int IDEX_W  = $bits(idex_t);
    localparam int EXMEM_W = $bits(exmem_t);
    localparam int MEMWB_W = $bits(memwb_t);

    ex_ctl_t  dec_ex;
    mem_ctl_t dec_mem;
    wb_ctl_t  dec_wb;

    idex_t  ie_d, ie_q;
    exmem_t em_d, em_q;
    memwb_t mw_d, mw_q;
    logic [IDEX_W-1:0]  ie_vec;
    logic [EXMEM_W-1:0] em_vec;
    logic [MEMWB_W-1:0] mw_vec;

    logic [REG_AW-1:0] ex_dst;
    logic ie_reg_wr, ie_mem_wr;

    pcp_decoder #(.OPC_W(OPC_W), .FUN_W(FUN_W)) dec_i (
        .opcode  (id_instr[INSTR_W-1:OPC_LSB]),
        .funct   (id_instr[FUN_W-1:0]),
        .ex_ctl  (dec_ex),
        .mem_ctl (dec_mem),
        .wb_ctl  (dec_wb)
    );

    // decode -> execute, bubble strips the side effects
    always_comb begin
        ie_d.ex  = dec_ex;
        ie_d.mem = dec_mem;
        ie_d.wb  = dec_wb;
        ie_d.rt  = id_instr[RT_LSB +: REG_AW];
        ie_d.rd  = id_instr[RD_LSB +: REG_AW];
        if (id_bubble) begin
            ie_d.wb.reg_wr  = 1'b0;
            ie_d.mem.wr     = 1'b0;
            ie_d.mem.branch = 1'b0;
        end
    end

    pcp_stage_reg #(.W(IDEX_W)) idex_i (
        .clk (clk), .rst_n (rst_n), .d (ie_d), .q (ie_vec)
    );
    assign ie_q = idex_t'(ie_vec);

    assign ex_dst = ie_q.ex.dst_rd ? ie_q.rd : ie_q.rt;

    // execute -> memory, flush strips the side effects
    always_comb begin
        em_d.mem = ie_q.mem;
        em_d.wb  = ie_q.wb;
        em_d.dst = ex_dst;
        if (ex_flush) begin
            em_d.wb.reg_wr  = 1'b0;
            em_d.mem.wr     = 1'b0;
            em_d.mem.branch = 1'b0;
        end
    end

    pcp_stage_reg #(.W(EXMEM_W)) exmem_i (
        .clk (clk), .rst_n (rst_n), .d (em_d), .q (em_vec)
    );
    assign em_q = exmem_t'(em_vec);

    // memory -> write-back
    always_comb begin
        mw_d.wb  = em_q.wb;
        mw_d.dst = em_q.dst;
    end

    pcp_stage_reg #(.W(MEMWB_W)) memwb_i (
        .clk (clk), .rst_n (rst_n), .d (mw_d), .q (mw_vec)
    );
    assign mw_q = memwb_t'(mw_vec);

    assign ie_reg_wr = ie_q.wb.reg_wr;
    assign ie_mem_wr = ie_q.mem.wr;

    assign ex_sign_ext   = ie_q.ex.sign_ext;
    assign ex_alu_imm    = ie_q.ex.alu_imm;
    assign ex_alu_fn     = ie_q.ex.alu_fn;
    assign ex_dst_rd     = ie_q.ex.dst_rd;
    assign ex_dst_reg    = ex_dst;
    assign mem_wr_en     = em_q.mem.wr;
    assign mem_rd_en     = em_q.mem.rd;
    assign mem_branch    = em_q.mem.branch;
    assign mem_dst_reg   = em_q.dst;
    assign wb_mem_to_reg = mw_q.wb.mem_to_reg;
    assign wb_reg_wr     = mw_q.wb.reg_wr;
    assign wb_dst_reg    = mw_q.dst;

endmodule

// File: rtl/pcp_ctrl_pipe_chk.sv
module pcp_ctrl_pipe_chk #(
    parameter int INSTR_W = 32,
    parameter int REG_AW  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] id_instr,
    input logic               id_bubble,
    input logic               ex_flush,
    input logic               ie_reg_wr,
    input logic               ie_mem_wr,
    input logic [REG_AW-1:0]  ex_dst_reg,
    input logic [REG_AW-1:0]  mem_dst_reg,
    input logic [REG_AW-1:0]  wb_dst_reg,
    input logic               mem_wr_en,
    input logic               mem_rd_en,
    input logic               mem_branch
);

    logic [5:0] opc;
    logic       opc_known;
    assign opc = id_instr[INSTR_W-1 -: 6];
    assign opc_known = (opc == 6'h00) || (opc == 6'h23) || (opc == 6'h2B) ||
                       (opc == 6'h04) || (opc == 6'h0D) || (opc == 6'h08);

    a_r5_dst_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_dst_reg == $past(ex_dst_reg)));

    a_r5_dst_to_wb: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wb_dst_reg == $past(mem_dst_reg)));

    a_r7_bubble_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        id_bubble |=> (!ie_reg_wr && !ie_mem_wr));

    a_r8_flush_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        ex_flush |=> (!mem_wr_en && !mem_branch));

    a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !opc_known |=> (!ie_reg_wr && !ie_mem_wr));

    a_r6_reg_type_mem_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 6'h00) |=> ##1 (!mem_wr_en && !mem_rd_en));

endmodule

bind pcp_ctrl_pipe pcp_ctrl_pipe_chk #(.INSTR_W(INSTR_W), .REG_AW(REG_AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_instr    (id_instr),
    .id_bubble   (id_bubble),
    .ex_flush    (ex_flush),
    .ie_reg_wr   (ie_reg_wr),
    .ie_mem_wr   (ie_mem_wr),
    .ex_dst_reg  (ex_dst_reg),
    .mem_dst_reg (mem_dst_reg),
    .wb_dst_reg  (wb_dst_reg),
    .mem_wr_en   (mem_wr_en),
    .mem_rd_en   (mem_rd_en),
    .mem_branch  (mem_branch)
);

// File: tb/pcp_ctrl_pipe_tb.sv
module pcp_ctrl_pipe_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] id_instr = '0;
    logic        id_bubble = 1'b0;
    logic        ex_flush = 1'b0;
    logic        ex_sign_ext, ex_alu_imm, ex_dst_rd;
    logic [2:0]  ex_alu_fn;
    logic [4:0]  ex_dst_reg, mem_dst_reg, wb_dst_reg;
    logic        mem_wr_en, mem_rd_en, mem_branch, wb_mem_to_reg, wb_reg_wr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcp_ctrl_pipe dut_i (
        .clk (clk), .rst_n (rst_n), .id_instr (id_instr),
        .id_bubble (id_bubble), .ex_flush (ex_flush),
        .ex_sign_ext (ex_sign_ext), .ex_alu_imm (ex_alu_imm),
        .ex_alu_fn (ex_alu_fn), .ex_dst_rd (ex_dst_rd),
        .ex_dst_reg (ex_dst_reg), .mem_wr_en (mem_wr_en),
        .mem_rd_en (mem_rd_en), .mem_branch (mem_branch),
        .mem_dst_reg (mem_dst_reg), .wb_mem_to_reg (wb_mem_to_reg),
        .wb_reg_wr (wb_reg_wr), .wb_dst_reg (wb_dst_reg)
    );

    typedef struct packed {
        logic       sx, imm;
        logic [2:0] fn;
        logic       drd, mwr, mrd, br, m2r, rwr;
        logic [4:0] dst;
    } bctl_t;

    bctl_t s_ex, s_mem, s_wb;

    localparam logic [31:0] NOP = 32'hFC00_0000;

    function automatic bctl_t model(input logic [31:0] ins);
        bctl_t c = '0;
        logic [5:0] op = ins[31:26];
        logic [5:0] fu = ins[5:0];
        case (op)
            6'h00: begin
                c.sx = 1; c.drd = 1; c.rwr = 1;
                case (fu)
                    6'h20: c.fn = 0;
                    6'h22: c.fn = 1;
                    6'h24: c.fn = 2;
                    6'h25: c.fn = 3;
                    6'h2A: c.fn = 4;
                    default: c = '0;
                endcase
            end
            6'h23: begin c.sx = 1; c.imm = 1; c.mrd = 1; c.m2r = 1; c.rwr = 1; end
            6'h2B: begin c.sx = 1; c.imm = 1; c.mwr = 1; end
            6'h04: begin c.sx = 1; c.fn = 1; c.br = 1; end
            6'h0D: begin c.imm = 1; c.fn = 3; c.rwr = 1; end
            6'h08: begin c.sx = 1; c.imm = 1; c.rwr = 1; end
            default: c = '0;
        endcase
        c.dst = c.drd ? ins[15:11] : ins[20:16];
        return c;
    endfunction

    function automatic logic [31:0] mk_r(input logic [4:0] rt, rd, input logic [5:0] fu);
        return {6'h00, 5'd1, rt, rd, 5'd0, fu};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rt);
        return {op, 5'd2, rt, 16'h1234};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] ins, input logic bub, input logic fl);
        bctl_t nx;
        id_instr  = ins;
        id_bubble = bub;
        ex_flush  = fl;
        s_wb  = s_mem;
        s_mem = s_ex;
        if (fl) begin s_mem.rwr = 0; s_mem.mwr = 0; s_mem.br = 0; end
        nx = model(ins);
        if (bub) begin nx.rwr = 0; nx.mwr = 0; nx.br = 0; end
        s_ex = nx;
        @(posedge clk);
        @(negedge clk);
        chk("R2 ex controls", {ex_sign_ext, ex_alu_imm, ex_alu_fn, ex_dst_rd},
            {s_ex.sx, s_ex.imm, s_ex.fn, s_ex.drd});
        chk("R5 ex dst", ex_dst_reg, s_ex.dst);
        chk("R3 mem controls", {mem_wr_en, mem_rd_en, mem_branch},
            {s_mem.mwr, s_mem.mrd, s_mem.br});
        chk("R5 mem dst", mem_dst_reg, s_mem.dst);
        chk("R4 wb controls", {wb_mem_to_reg, wb_reg_wr}, {s_wb.m2r, s_wb.rwr});
        chk("R5 wb dst", wb_dst_reg, s_wb.dst);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        int unused;
        unused = $urandom(32'd20240611);
        s_ex = '0; s_mem = '0; s_wb = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {ex_sign_ext, ex_alu_imm, ex_alu_fn, ex_dst_rd, mem_wr_en,
            mem_rd_en, mem_branch, wb_mem_to_reg, wb_reg_wr}, 0);
        chk("R1 reset dst", {ex_dst_reg, mem_dst_reg, wb_dst_reg}, 0);
        rst_n = 1'b1;

        // R6 register-type: memory idle, write in stage 5
        step(mk_r(5'd3, 5'd7, 6'h20), 0, 0);
        chk("R5 rd chosen", ex_dst_reg, 7);
        step(NOP, 0, 0);
        chk("R6 mem idle", {mem_wr_en, mem_rd_en}, 0);
        chk("R6 no early write", wb_reg_wr, 0);
        step(NOP, 0, 0);
        chk("R6 write in wb", {wb_reg_wr, wb_dst_reg}, {1'b1, 5'd7});

        // load through all stages
        step(mk_i(6'h23, 5'd9), 0, 0);
        step(NOP, 0, 0);
        chk("R3 load read", mem_rd_en, 1);
        step(NOP, 0, 0);
        chk("R4 load wb", {wb_mem_to_reg, wb_reg_wr, wb_dst_reg}, {2'b11, 5'd9});

        // R7 bubble on add-immediate
        step(mk_i(6'h08, 5'd4), 1, 0);
        chk("R7 other ex controls kept", {ex_sign_ext, ex_alu_imm}, 2'b11);
        step(NOP, 0, 0);
        step(NOP, 0, 0);
        chk("R7 bubble removes write", wb_reg_wr, 0);

        // R8 flush of a store and a branch
        step(mk_i(6'h2B, 5'd6), 0, 0);
        step(NOP, 0, 1);
        chk("R8 flushed store", mem_wr_en, 0);
        step(mk_i(6'h04, 5'd6), 0, 0);
        step(NOP, 0, 1);
        chk("R8 flushed branch", mem_branch, 0);

        // R9 unrecognised opcode and funct
        step({6'h3F, 26'h3FF_FFFF}, 0, 0);
        step(mk_r(5'd2, 5'd8, 6'h3F), 0, 0);
        step(NOP, 0, 0);
        chk("R9 unknown op no write", wb_reg_wr, 0);
        chk("R9 unknown funct no mem", {mem_wr_en, mem_rd_en, mem_branch}, 0);
        step(NOP, 0, 0);
        chk("R9 unknown funct no write", wb_reg_wr, 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [5:0]  ops [7] = '{6'h00, 6'h23, 6'h2B, 6'h04, 6'h0D, 6'h08, 6'h15};
            logic [5:0]  fus [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h07};
            logic [31:0] ins;
            ins = $urandom;
            ins[31:26] = ops[$urandom % 7];
            ins[5:0]   = fus[$urandom % 6];
            step(ins, ($urandom % 8) == 0, ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule